// File: doc/BRIEF.md
# Invalidation Queue Enable Controller

This block is the register-side control for a circular queue of invalidation descriptors in an address-translation unit. Software programs a queue address register, which holds a 4 KiB-aligned base and a size field, and a tail register. It then sets an enable command. The block keeps the head pointer and reports an enable status. While the head trails the tail, it requests descriptor reads through a simple request/acknowledge port. Each acknowledge consumes one 16-byte descriptor and moves the head forward.

Drivers are expected to zero the tail before enabling, but some do not. A non-zero tail at enable time is tolerated. The enable still completes, a one-cycle warning pulse marks the protocol breach, and fetching starts at once, exactly as if the tail had been written just after the enable. A pending queue error fault blocks fetching on every path, including this one.

Top module: `invq_ctrl`

## Requirements
- R1: After reset the enable status, fault status, warning pulse and fetch request are all 0, and the head pointer is 0.
- R2: On an accepted enable, the queue base is latched from the address register's base field, with bits 11:0 of the address forced to zero. Every fetch address is that base plus 16 times the head. Writes to the address register while the queue is enabled do not change the fetch addresses.
- R3: The queue holds 2^(size+8) entries, where size is the field captured at enable. The head wraps from entry count minus one to 0.
- R4: A write of 1 to the enable command while the queue is disabled sets the enable status on the next cycle, whatever the tail value.
- R5: When an enable is accepted with a non-zero tail, a warning pulse lasting exactly one cycle appears in the same cycle that the enable status rises. That cycle also carries a fetch request, unless a fault is pending.
- R6: The fetch request is high exactly when all of these hold: the queue is enabled, no fault is pending, the tail is below the entry count, and the head differs from the tail. Each acknowledge taken while the request is high advances the head by one. An acknowledge taken while the request is low has no effect.
- R7: While the queue is enabled, a tail at or beyond the entry count sets the fault status on the next cycle and stops fetching. The fault stays set until a fault-clear pulse arrives while the tail is in range.
- R8: If a fault is already pending at enable, the enable completes but no fetch is requested. Clearing the fault then starts fetching.
- R9: A disable write is accepted only when the head equals the tail. On the next cycle the enable status is 0 and the head is 0. Otherwise the queue stays enabled.
- R10: While the queue is disabled, tail writes update the tail but never raise a fetch request or a fault.
- R11: A tail write and a fetch acknowledge in the same cycle both take effect: the head advances and the new tail becomes the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Write strobe for the enable command |
| cmd_en | input | 1 | Enable command value (1 = enable, 0 = disable) |
| iqa_we | input | 1 | Write strobe for the queue address register |
| iqa_base_wdata | input | ADDR_W-12 | Base address bits ADDR_W-1:12 |
| iqa_qs_wdata | input | QS_W | Size field (entries = 2^(size+8)) |
| tail_we | input | 1 | Write strobe for the tail register |
| tail_wdata | input | PTR_W | Tail value in entries |
| flt_clr | input | 1 | Clear pulse for the queue error fault |
| fetch_ack | input | 1 | Descriptor read accepted |
| en_sts | output | 1 | Queue enable status |
| flt_sts | output | 1 | Queue error fault status |
| tail_warn | output | 1 | Pulse: enable accepted with a non-zero tail |
| head_ptr | output | PTR_W | Current head, in entries |
| fetch_req | output | 1 | Descriptor read request |
| fetch_addr | output | ADDR_W | Byte address of the descriptor at the head |

## Verification
The interesting collisions are a tail write landing in the same cycle as a fetch acknowledge, and an enable landing in the cycle after a tail write. In both cases the head update and the new tail target must combine without either one being lost. The bench provokes the first collision directly while the queue is mid-drain. It then mixes random tail writes, acknowledges, fault clears and enable or disable writes over thousands of cycles. After every cycle it compares the head, request, address, fault and warning outputs against a model built from the requirements.

// File: rtl/invq_pkg.sv
package invq_pkg;
    localparam int BASE_ALIGN_LOG2 = 12;
    localparam int DESC_LOG2       = 4;
    localparam int QS_BIAS         = 8;

    typedef enum logic {
        Q_IDLE = 1'b0,
        Q_RUN  = 1'b1
    } qstate_e;
endpackage

// File: rtl/invq_regs.sv
module invq_regs
    import invq_pkg::*;
#(
    parameter int BASE_W = 36,
    parameter int QS_W   = 3,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iqa_we,
    input  logic [BASE_W-1:0] iqa_base_wdata,
    input  logic [QS_W-1:0]   iqa_qs_wdata,
    input  logic              tail_we,
    input  logic [PTR_W-1:0]  tail_wdata,
    input  logic              flt_clr,
    input  logic              q_on,
    input  logic [PTR_W-1:0]  entries,
    output logic [BASE_W-1:0] base_fld,
    output logic [QS_W-1:0]   qs_fld,
    output logic [PTR_W-1:0]  tail_q,
    output logic              tail_ok,
    output logic              flt
);
    logic flt_set;

    assign tail_ok = (tail_q < entries);
    assign flt_set = q_on && !tail_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_fld <= '0;
            qs_fld   <= '0;
            tail_q   <= '0;
            flt      <= 1'b0;
        end else begin
            if (iqa_we) begin
                base_fld <= iqa_base_wdata;
                qs_fld   <= iqa_qs_wdata;
            end
            if (tail_we)
                tail_q <= tail_wdata;
            if (flt_set)
                flt <= 1'b1;
            else if (flt_clr)
                flt <= 1'b0;
        end
    end

    // R7: an out-of-range tail seen while running raises the fault
    p_flt_set_r7: assert property (@(posedge clk) disable iff (rst)
        (q_on && (tail_q >= entries)) |=> flt);

    // R7: the fault holds until a clear arrives
    p_flt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flt && !flt_clr) |=> flt);

    // R10: no fault can appear while the queue is off
    p_flt_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!q_on && !flt) |=> !flt);
endmodule

// File: rtl/invq_fetch.sv
module invq_fetch
    import invq_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int PTR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_on,
    input  logic              flt,
    input  logic              tail_ok,
    input  logic [PTR_W-1:0]  tail_q,
    input  logic [ADDR_W-1:0] base,
    input  logic [PTR_W-1:0]  entries,
    input  logic              ack,
    input  logic              head_clr,
    output logic [PTR_W-1:0]  head,
    output logic              req,
    output logic [ADDR_W-1:0] addr
);
    logic             step;
    logic             at_last;
    logic [PTR_W-1:0] head_nxt;

    assign req      = q_on && !flt && tail_ok && (head != tail_q);
    assign step     = req && ack;
    assign at_last  = (head == (entries - PTR_W'(1)));
    assign head_nxt = at_last ? '0 : head + PTR_W'(1);
    assign addr     = base + (ADDR_W'(head) << DESC_LOG2);

    always_ff @(posedge clk) begin
        if (rst)
            head <= '0;
        else if (head_clr)
            head <= '0;
        else if (step)
            head <= head_nxt;
    end

    // R8: no request while a fault is pending or the queue is off
    p_req_gate_r8: assert property (@(posedge clk) disable iff (rst)
        req |-> (q_on && !flt));

    // R3: the last slot wraps to zero
    p_head_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && at_last && !head_clr) |=> (head == '0));

    // R6: the head moves only on an accepted acknowledge or a clear
    p_head_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!step && !head_clr) |=> $stable(head));

    // R3: the head stays inside the ring while running
    p_head_range_r3: assert property (@(posedge clk) disable iff (rst)
        q_on |-> (head < entries));
endmodule

// File: rtl/invq_ctrl.sv
module invq_ctrl
    import invq_pkg::*;
#(
    parameter  int ADDR_W = 48,
    parameter  int QS_W   = 3,
    localparam int BASE_W = ADDR_W - BASE_ALIGN_LOG2,
    localparam int PTR_W  = (1 << QS_W) + QS_BIAS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              cmd_en,
    input  logic              iqa_we,
    input  logic [BASE_W-1:0] iqa_base_wdata,
    input  logic [QS_W-1:0]   iqa_qs_wdata,
    input  logic              tail_we,
    input  logic [PTR_W-1:0]  tail_wdata,
    input  logic              flt_clr,
    input  logic              fetch_ack,
    output logic              en_sts,
    output logic              flt_sts,
    output logic              tail_warn,
    output logic [PTR_W-1:0]  head_ptr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr
);
    qstate_e           state;
    logic [QS_W-1:0]   qs_q;
    logic [ADDR_W-1:0] base_q;
    logic              warn_q;
    logic [PTR_W-1:0]  entries;
    logic [BASE_W-1:0] base_fld;
    logic [QS_W-1:0]   qs_fld;
    logic [PTR_W-1:0]  tail_q;
    logic              tail_ok;
    logic              flt;
    logic              q_on;
    logic              on_acc;
    logic              off_acc;

    assign q_on    = (state == Q_RUN);
    assign entries = PTR_W'(1) << (QS_BIAS + int'(qs_q));
    assign on_acc  = cmd_we && cmd_en && !q_on;
    assign off_acc = cmd_we && !cmd_en && q_on && (head_ptr == tail_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= Q_IDLE;
            qs_q   <= '0;
            base_q <= '0;
            warn_q <= 1'b0;
        end else begin
            warn_q <= on_acc && (tail_q != '0);
            if (on_acc) begin
                state  <= Q_RUN;
                qs_q   <= qs_fld;
                base_q <= {base_fld, {BASE_ALIGN_LOG2{1'b0}}};
            end else if (off_acc) begin
                state <= Q_IDLE;
            end
        end
    end

    invq_regs #(
        .BASE_W (BASE_W),
        .QS_W   (QS_W),
        .PTR_W  (PTR_W)
    ) u_regs (
        .clk            (clk),
        .rst            (rst),
        .iqa_we         (iqa_we),
        .iqa_base_wdata (iqa_base_wdata),
        .iqa_qs_wdata   (iqa_qs_wdata),
        .tail_we        (tail_we),
        .tail_wdata     (tail_wdata),
        .flt_clr        (flt_clr),
        .q_on           (q_on),
        .entries        (entries),
        .base_fld       (base_fld),
        .qs_fld         (qs_fld),
        .tail_q         (tail_q),
        .tail_ok        (tail_ok),
        .flt            (flt)
    );

    invq_fetch #(
        .ADDR_W (ADDR_W),
        .PTR_W  (PTR_W)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .q_on     (q_on),
        .flt      (flt),
        .tail_ok  (tail_ok),
        .tail_q   (tail_q),
        .base     (base_q),
        .entries  (entries),
        .ack      (fetch_ack),
        .head_clr (off_acc),
        .head     (head_ptr),
        .req      (fetch_req),
        .addr     (fetch_addr)
    );

    assign en_sts    = q_on;
    assign flt_sts   = flt;
    assign tail_warn = warn_q;

    // R4: an enable write always leaves the queue running
    p_on_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_en) |=> en_sts);

    // R5: the warning pulse coincides with the status rising
    p_warn_rise_r5: assert property (@(posedge clk) disable iff (rst)
        tail_warn |-> $rose(en_sts));

    // R9: a disable with work outstanding is refused
    p_off_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_en && en_sts && (head_ptr != tail_q)) |=> en_sts);

    // R9: an accepted disable parks the head at zero
    p_off_head_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_en && en_sts && (head_ptr == tail_q)) |=> (!en_sts && head_ptr == '0));
endmodule

// File: tb/invq_ctrl_test.sv
module invq_ctrl_test;
    localparam int ADDR_W = 48;
    localparam int QS_W   = 3;
    localparam int BASE_W = ADDR_W - 12;
    localparam int PTR_W  = (1 << QS_W) + 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_we = 0, cmd_en = 0, iqa_we = 0, tail_we = 0, flt_clr = 0, fetch_ack = 0;
    logic [BASE_W-1:0] iqa_base_wdata = '0;
    logic [QS_W-1:0]   iqa_qs_wdata = '0;
    logic [PTR_W-1:0]  tail_wdata = '0;
    logic              en_sts, flt_sts, tail_warn, fetch_req;
    logic [PTR_W-1:0]  head_ptr;
    logic [ADDR_W-1:0] fetch_addr;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit                m_en, m_flt, m_warn;
    logic [BASE_W-1:0] m_iqa_base;
    logic [QS_W-1:0]   m_iqa_qs, m_qs;
    logic [ADDR_W-1:0] m_base;
    logic [PTR_W-1:0]  m_head, m_tail;

    always #2 clk = ~clk;

    invq_ctrl #(.ADDR_W(ADDR_W), .QS_W(QS_W)) uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_en(cmd_en),
        .iqa_we(iqa_we), .iqa_base_wdata(iqa_base_wdata), .iqa_qs_wdata(iqa_qs_wdata),
        .tail_we(tail_we), .tail_wdata(tail_wdata), .flt_clr(flt_clr), .fetch_ack(fetch_ack),
        .en_sts(en_sts), .flt_sts(flt_sts), .tail_warn(tail_warn), .head_ptr(head_ptr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr)
    );

    function automatic int ents(input logic [QS_W-1:0] qs);
        return 1 << (int'(qs) + 8);
    endfunction

    function automatic bit exp_req();
        return m_en && !m_flt && (int'(m_tail) < ents(m_qs)) && (m_head != m_tail);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [ADDR_W-1:0] ea;
        ea = m_base + (ADDR_W'(m_head) << 4);
        chk(en_sts == m_en, "R4/R9 en_sts", 64'(en_sts), 64'(m_en));
        chk(head_ptr == m_head, "R6 head", 64'(head_ptr), 64'(m_head));
        chk(fetch_req == exp_req(), "R6 fetch_req", 64'(fetch_req), 64'(exp_req()));
        if (exp_req())
            chk(fetch_addr == ea, "R2 fetch_addr", 64'(fetch_addr), 64'(ea));
        chk(flt_sts == m_flt, "R7 flt_sts", 64'(flt_sts), 64'(m_flt));
        chk(tail_warn == m_warn, "R5 tail_warn", 64'(tail_warn), 64'(m_warn));
    endtask

    task automatic step(input bit cw, input bit ce, input bit iw, input logic [BASE_W-1:0] ib,
                        input logic [QS_W-1:0] iq, input bit tw, input logic [PTR_W-1:0] td,
                        input bit clr, input bit ack);
        bit                on, off, rq;
        int                e;
        logic [PTR_W-1:0]  nh;
        cmd_we = cw; cmd_en = ce; iqa_we = iw; iqa_base_wdata = ib; iqa_qs_wdata = iq;
        tail_we = tw; tail_wdata = td; flt_clr = clr; fetch_ack = ack;
        e   = ents(m_qs);
        rq  = exp_req();
        on  = cw && ce && !m_en;
        off = cw && !ce && m_en && (m_head == m_tail);
        nh  = m_head;
        if (off) nh = '0;
        else if (rq && ack) nh = (int'(m_head) == e - 1) ? '0 : m_head + 1'b1;
        @(posedge clk);
        #1;
        m_warn = on && (m_tail != '0);
        if (m_en && int'(m_tail) >= e) m_flt = 1'b1;
        else if (clr) m_flt = 1'b0;
        if (on) begin
            m_en = 1'b1; m_qs = m_iqa_qs; m_base = {m_iqa_base, 12'h000};
        end else if (off) begin
            m_en = 1'b0;
        end
        m_head = nh;
        if (iw) begin m_iqa_base = ib; m_iqa_qs = iq; end
        if (tw) m_tail = td;
        cmd_we = 0; iqa_we = 0; tail_we = 0; flt_clr = 0; fetch_ack = 0;
        compare_all();
    endtask

    task automatic idle();            step(0, 0, 0, '0, '0, 0, '0, 0, 0); endtask
    task automatic ack1();            step(0, 0, 0, '0, '0, 0, '0, 0, 1); endtask
    task automatic wtail(input int v); step(0, 0, 0, '0, '0, 1, PTR_W'(v), 0, 0); endtask
    task automatic qon();             step(1, 1, 0, '0, '0, 0, '0, 0, 0); endtask
    task automatic qoff();            step(1, 0, 0, '0, '0, 0, '0, 0, 0); endtask
    task automatic fclr();            step(0, 0, 0, '0, '0, 0, '0, 1, 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit seen_wrap;
        void'($urandom(32'd20240611));
        m_en = 0; m_flt = 0; m_warn = 0; m_iqa_base = '0; m_iqa_qs = '0; m_qs = '0;
        m_base = '0; m_head = '0; m_tail = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        chk(en_sts == 0, "R1 en_sts", 64'(en_sts), 0);
        chk(flt_sts == 0, "R1 flt_sts", 64'(flt_sts), 0);
        chk(tail_warn == 0, "R1 tail_warn", 64'(tail_warn), 0);
        chk(fetch_req == 0, "R1 fetch_req", 64'(fetch_req), 0);
        chk(head_ptr == 0, "R1 head", 64'(head_ptr), 0);

        // program base 0xABCDE000, size 1 (512 entries)
        step(0, 0, 1, 36'h0000ABCDE, 3'd1, 0, '0, 0, 0);
        qon();
        chk(en_sts == 1 && tail_warn == 0 && fetch_req == 0, "R4 clean enable", {en_sts, tail_warn, fetch_req}, 64'b100);
        wtail(3);
        chk(fetch_req == 1 && fetch_addr == 48'hABCDE000, "R2 first addr", 64'(fetch_addr), 64'hABCDE000);
        repeat (3) ack1();
        chk(head_ptr == 3 && fetch_req == 0, "R6 drained", 64'(head_ptr), 3);
        ack1();
        chk(head_ptr == 3, "R6 stray ack ignored", 64'(head_ptr), 3);
        // R2: address register writes while running do not move the base
        step(0, 0, 1, 36'h011110000, 3'd0, 0, '0, 0, 0);
        wtail(4);
        chk(fetch_addr == 48'hABCDE030, "R2 base held", 64'(fetch_addr), 64'hABCDE030);
        ack1();
        qoff();
        chk(en_sts == 0 && head_ptr == 0, "R9 disable accepted", {en_sts, head_ptr}, 0);

        // R10: tail writes while disabled
        wtail(5); idle();
        chk(fetch_req == 0, "R10 no fetch when off", 64'(fetch_req), 0);
        wtail(700); idle();
        chk(flt_sts == 0 && fetch_req == 0, "R10 no fault when off", {flt_sts, fetch_req}, 0);
        wtail(5);

        // R5: enable with a non-zero tail
        qon();
        chk(tail_warn == 1 && en_sts == 1 && fetch_req == 1, "R5 enable with tail", {tail_warn, en_sts, fetch_req}, 64'b111);
        chk(fetch_addr == 48'h11110000000, "R5 fetch base", 64'(fetch_addr), 64'h11110000000);
        idle();
        chk(tail_warn == 0, "R5 single pulse", 64'(tail_warn), 0);
        qoff();
        chk(en_sts == 1, "R9 disable refused", 64'(en_sts), 1);

        // R11: tail write and acknowledge together
        step(0, 0, 0, '0, '0, 1, PTR_W'(7), 0, 1);
        chk(head_ptr == 1, "R11 head advanced", 64'(head_ptr), 1);
        while (fetch_req) ack1();
        chk(head_ptr == 7, "R11 new tail reached", 64'(head_ptr), 7);

        // R3: wrap in a 256-entry ring
        wtail(2);
        seen_wrap = 0;
        while (fetch_req) begin
            if (head_ptr == 255) begin
                ack1();
                chk(head_ptr == 0, "R3 wrap to zero", 64'(head_ptr), 0);
                seen_wrap = 1;
            end else begin
                ack1();
            end
        end
        chk(seen_wrap && head_ptr == 2, "R3 drained past wrap", 64'(head_ptr), 2);

        // R7: out-of-range tail
        wtail(256); idle();
        chk(flt_sts == 1 && fetch_req == 0, "R7 fault set", {flt_sts, fetch_req}, 64'b10);
        wtail(3);
        chk(flt_sts == 1 && fetch_req == 0, "R7 fault sticky", {flt_sts, fetch_req}, 64'b10);
        fclr();
        chk(flt_sts == 0 && fetch_req == 1, "R7 fault cleared", {flt_sts, fetch_req}, 64'b01);
        ack1();

        // R8: fault pending on the enable path
        wtail(300); idle();
        wtail(3);
        qoff();
        chk(en_sts == 0 && flt_sts == 1, "R8 off with fault", {en_sts, flt_sts}, 64'b01);
        wtail(4);
        qon();
        chk(en_sts == 1 && tail_warn == 1 && fetch_req == 0, "R8 enable blocked", {en_sts, tail_warn, fetch_req}, 64'b110);
        fclr();
        chk(fetch_req == 1, "R8 fetch after clear", 64'(fetch_req), 1);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            int e;
            bit cw, ce, iw, tw, clr, ak;
            logic [PTR_W-1:0] td;
            r  = int'($urandom_range(0, 99));
            e  = ents(m_qs);
            cw = 0; ce = 0; iw = 0; tw = 0; clr = 0; td = '0;
            ak = ($urandom_range(0, 9) < 6);
            if (r < 10) begin
                tw = 1; td = PTR_W'($urandom_range(0, e - 1));
            end else if (r < 12) begin
                tw = 1; td = PTR_W'(e + int'($urandom_range(0, 20)));
            end else if (r < 16) begin
                clr = 1;
            end else if (r < 19) begin
                iw = 1;
            end else if (r < 23) begin
                cw = 1; ce = !m_en;
            end
            step(cw, ce, iw, BASE_W'({$urandom, $urandom}), QS_W'($urandom_range(0, 1)), tw, td, clr, ak);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule